// File: doc/BRIEF.md
# Integer Add/Subtract Unit

This block is the add/subtract datapath of a fixed-point execution pipe. It is purely combinational. Each cycle it receives an already decoded operation, two register operands, a signed immediate field, and the current carry, overflow and summary-overflow state. It returns the sum, the updated carry and overflow state, and a four-bit condition field. The surrounding pipeline writes that field to the first condition register slot when the instruction is a record form.

Seven operations share one carry-chain adder. An input stage picks the two addends and the carry-in for each operation. It takes the operands from the registers, the sign-extended immediate (plain or shifted left), an all-ones or all-zero constant, or the inverted first operand. When the decoder flags the register field of an immediate add as zero, the base is a literal zero and not the register contents. Carries are taken at the top bit and at the half-word boundary, so 64-bit and 32-bit carry and overflow are produced together.

Top module: `int_addsub`

## Requirements
- R1: Operation code 0 (add) gives RA + RB modulo 2^XLEN. For codes 0, 1, 2, 3 and 7, the carry outputs ca_o and ca32_o equal ca_i and ca32_i.
- R2: Operation code 1 (subtract-from) gives RB − RA, formed as the inverse of RA plus RB plus one.
- R3: Operation code 2 (add immediate) gives base + sign-extended imm_i. The base is zero when ra_zero_i is 1 and RA otherwise.
- R4: Operation code 3 (add immediate shifted) gives base + (sign-extended imm_i shifted left by SHIFT bits), with the same zero-base rule as R3. With the defaults, an immediate of 1 and ra_zero_i = 1 give 0x10000 whatever RA holds.
- R5: Operation code 4 (extended add) gives RA + RB + ca_i. ca_o is the carry out of bit XLEN−1, and ca32_o is the carry out of bit HALF−1.
- R6: Operation code 5 (add to minus one) gives RA + ca_i − 1, with carries as in R5. With ca_i = 0 and a nonzero RA, ca_o is 1.
- R7: Operation code 6 (add to zero) gives RA + ca_i, with carries as in R5. With ca_i = 0 the result equals RA and both carries are 0.
- R8: When oe_i = 1 on codes 0, 1, 4, 5, 6 and 7, ov_o flags signed overflow of the full-width result and ov32_o flags signed overflow of the low HALF bits. so_o becomes so_i OR ov_o. In every other case ov_o, ov32_o and so_o equal ov_i, ov32_i and so_i.
- R9: cr0_o bit 3 is set for a negative result, bit 2 for a positive nonzero result and bit 1 for a zero result, with the result read as a signed XLEN-bit value. Bit 0 is the updated so_o.
- R10: Operation code 7 is reserved and behaves exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Decoded operation code |
| oe_i | input | 1 | Overflow-enabled form |
| ra_zero_i | input | 1 | Register field of an immediate add was zero |
| ra_i | input | XLEN | First register operand |
| rb_i | input | XLEN | Second register operand |
| imm_i | input | IMM_W | Signed immediate field |
| ca_i | input | 1 | Incoming carry |
| ca32_i | input | 1 | Incoming half-width carry |
| so_i | input | 1 | Incoming summary overflow |
| ov_i | input | 1 | Incoming overflow |
| ov32_i | input | 1 | Incoming half-width overflow |
| res_o | output | XLEN | Result |
| ca_o | output | 1 | Updated carry |
| ca32_o | output | 1 | Updated half-width carry |
| ov_o | output | 1 | Updated overflow |
| ov32_o | output | 1 | Updated half-width overflow |
| so_o | output | 1 | Updated summary overflow |
| cr0_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench goes after the operand order of subtract-from: a swapped subtractor returns the negated difference. It checks the literal-zero base of the immediate adds, where a wrong design adds a stale register. It checks the borrow of add-to-minus-one, where a missing carry-out would leave the carry bit clear after a plain decrement. It also covers the half-word carry and overflow tap: taken from the wrong bit, it misreports ca32_o and ov32_o while the full-width flags still look right. On the condition side it looks for a summary-overflow bit that is not sticky or that misses the condition field, and for overflow flags that change under forms that must preserve them. An exhaustive sweep of a 5-bit configuration reaches every operand, carry-in and control combination, so sign-boundary wrap cases cannot slip through.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_SUBF  = 3'd1,
      OP_ADDI  = 3'd2,
      OP_ADDIS = 3'd3,
      OP_ADDE  = 3'd4,
      OP_ADDME = 3'd5,
      OP_ADDZE = 3'd6,
      OP_RSV   = 3'd7
   } addsub_op_e;

   // condition field bit positions
   localparam int unsigned CR_LT = 3;
   localparam int unsigned CR_GT = 2;
   localparam int unsigned CR_EQ = 1;
   localparam int unsigned CR_SO = 0;

endpackage

// File: rtl/int_addsub_opsel.sv
module int_addsub_opsel
   import addsub_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IMM_W = 16,
   parameter int unsigned SHIFT = 16
) (
   input  logic [2:0]      op_i,
   input  logic            ra_zero_i,
   input  logic [XLEN-1:0] ra_i,
   input  logic [XLEN-1:0] rb_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic            ca_i,
   output logic [XLEN-1:0] add_a_o,
   output logic [XLEN-1:0] add_b_o,
   output logic            cin_o,
   output logic            oe_ok_o,
   output logic            carry_upd_o
);

   localparam int unsigned EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] imm_shl;
   logic [XLEN-1:0] base;
   addsub_op_e      op;

   assign op      = addsub_op_e'(op_i);
   assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign imm_shl = imm_ext << SHIFT;
   assign base    = ra_zero_i ? '0 : ra_i;

   always_comb begin
      add_a_o     = ra_i;
      add_b_o     = rb_i;
      cin_o       = 1'b0;
      oe_ok_o     = 1'b1;
      carry_upd_o = 1'b0;
      unique case (op)
         OP_SUBF: begin
            add_a_o = ~ra_i;
            cin_o   = 1'b1;
         end
         OP_ADDI: begin
            add_a_o = base;
            add_b_o = imm_ext;
            oe_ok_o = 1'b0;
         end
         OP_ADDIS: begin
            add_a_o = base;
            add_b_o = imm_shl;
            oe_ok_o = 1'b0;
         end
         OP_ADDE: begin
            cin_o       = ca_i;
            carry_upd_o = 1'b1;
         end
         OP_ADDME: begin
            add_b_o     = '1;
            cin_o       = ca_i;
            carry_upd_o = 1'b1;
         end
         OP_ADDZE: begin
            add_b_o     = '0;
            cin_o       = ca_i;
            carry_upd_o = 1'b1;
         end
         default: begin
            // OP_ADD and the reserved code share the plain sum
         end
      endcase
   end

endmodule

// File: rtl/int_addsub_adder.sv
module int_addsub_adder #(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned HALF        = 32,
   parameter bit          CARRY_SPLIT = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            cin_i,
   output logic [XLEN-1:0] sum_o,
   output logic            c_hi_o,
   output logic            c_lo_o,
   output logic            ov_hi_o,
   output logic            ov_lo_o
);

   localparam int unsigned HI_W = XLEN - HALF;

   generate
      if (CARRY_SPLIT) begin : g_split
         // two chained adders: the half carry is a real adder output
         logic [HALF:0] lo_sum;
         logic [HI_W:0] hi_sum;
         assign lo_sum = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]}
                         + {{HALF{1'b0}}, cin_i};
         assign hi_sum = {1'b0, a_i[XLEN-1:HALF]} + {1'b0, b_i[XLEN-1:HALF]}
                         + {{HI_W{1'b0}}, lo_sum[HALF]};
         assign sum_o  = {hi_sum[HI_W-1:0], lo_sum[HALF-1:0]};
         assign c_lo_o = lo_sum[HALF];
         assign c_hi_o = hi_sum[HI_W];
      end else begin : g_flat
         // one wide adder: the half carry is recovered from the sum bit
         logic [XLEN:0] full_sum;
         assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{XLEN{1'b0}}, cin_i};
         assign sum_o    = full_sum[XLEN-1:0];
         assign c_hi_o   = full_sum[XLEN];
         assign c_lo_o   = a_i[HALF] ^ b_i[HALF] ^ full_sum[HALF];
      end
   endgenerate

   // signed overflow: like-signed addends, result sign differs
   assign ov_hi_o = (a_i[XLEN-1] ~^ b_i[XLEN-1]) & (sum_o[XLEN-1] ^ a_i[XLEN-1]);
   assign ov_lo_o = (a_i[HALF-1] ~^ b_i[HALF-1]) & (sum_o[HALF-1] ^ a_i[HALF-1]);

endmodule

// File: rtl/int_addsub_flags.sv
module int_addsub_flags
   import addsub_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] sum_i,
   input  logic            c_hi_i,
   input  logic            c_lo_i,
   input  logic            ov_hi_i,
   input  logic            ov_lo_i,
   input  logic            oe_i,
   input  logic            oe_ok_i,
   input  logic            carry_upd_i,
   input  logic            ca_i,
   input  logic            ca32_i,
   input  logic            so_i,
   input  logic            ov_i,
   input  logic            ov32_i,
   output logic            ca_o,
   output logic            ca32_o,
   output logic            ov_o,
   output logic            ov32_o,
   output logic            so_o,
   output logic [3:0]      cr0_o
);

   logic ov_en;
   logic is_zero;
   logic is_neg;

   assign ov_en   = oe_i & oe_ok_i;
   assign is_zero = ~|sum_i;
   assign is_neg  = sum_i[XLEN-1];

   assign ca_o   = carry_upd_i ? c_hi_i : ca_i;
   assign ca32_o = carry_upd_i ? c_lo_i : ca32_i;
   assign ov_o   = ov_en ? ov_hi_i : ov_i;
   assign ov32_o = ov_en ? ov_lo_i : ov32_i;
   assign so_o   = so_i | (ov_en & ov_hi_i);

   always_comb begin
      cr0_o        = '0;
      cr0_o[CR_LT] = is_neg;
      cr0_o[CR_GT] = ~is_neg & ~is_zero;
      cr0_o[CR_EQ] = is_zero;
      cr0_o[CR_SO] = so_o;
   end

endmodule

// File: rtl/int_addsub.sv
module int_addsub #(
   parameter int unsigned XLEN        = 64,
   parameter int unsigned HALF        = 32,
   parameter int unsigned IMM_W       = 16,
   parameter int unsigned SHIFT       = 16,
   parameter bit          CARRY_SPLIT = 1'b1
) (
   input  logic [2:0]       op_i,
   input  logic             oe_i,
   input  logic             ra_zero_i,
   input  logic [XLEN-1:0]  ra_i,
   input  logic [XLEN-1:0]  rb_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             ca_i,
   input  logic             ca32_i,
   input  logic             so_i,
   input  logic             ov_i,
   input  logic             ov32_i,
   output logic [XLEN-1:0]  res_o,
   output logic             ca_o,
   output logic             ca32_o,
   output logic             ov_o,
   output logic             ov32_o,
   output logic             so_o,
   output logic [3:0]       cr0_o
);

   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("int_addsub: XLEN must be at least 4");
      end
      if (HALF == 0 || HALF >= XLEN) begin : g_bad_half
         $error("int_addsub: HALF must lie strictly inside XLEN");
      end
      if (IMM_W < 2 || IMM_W >= XLEN) begin : g_bad_imm
         $error("int_addsub: IMM_W must be in 2..XLEN-1");
      end
      if (SHIFT >= XLEN) begin : g_bad_shift
         $error("int_addsub: SHIFT must be below XLEN");
      end
   endgenerate

   logic [XLEN-1:0] add_a;
   logic [XLEN-1:0] add_b;
   logic            cin;
   logic            oe_ok;
   logic            carry_upd;
   logic            c_hi;
   logic            c_lo;
   logic            ov_hi;
   logic            ov_lo;

   int_addsub_opsel #(
      .XLEN  (XLEN),
      .IMM_W (IMM_W),
      .SHIFT (SHIFT)
   ) u_opsel (
      .op_i        (op_i),
      .ra_zero_i   (ra_zero_i),
      .ra_i        (ra_i),
      .rb_i        (rb_i),
      .imm_i       (imm_i),
      .ca_i        (ca_i),
      .add_a_o     (add_a),
      .add_b_o     (add_b),
      .cin_o       (cin),
      .oe_ok_o     (oe_ok),
      .carry_upd_o (carry_upd)
   );

   int_addsub_adder #(
      .XLEN        (XLEN),
      .HALF        (HALF),
      .CARRY_SPLIT (CARRY_SPLIT)
   ) u_adder (
      .a_i     (add_a),
      .b_i     (add_b),
      .cin_i   (cin),
      .sum_o   (res_o),
      .c_hi_o  (c_hi),
      .c_lo_o  (c_lo),
      .ov_hi_o (ov_hi),
      .ov_lo_o (ov_lo)
   );

   int_addsub_flags #(
      .XLEN (XLEN)
   ) u_flags (
      .sum_i       (res_o),
      .c_hi_i      (c_hi),
      .c_lo_i      (c_lo),
      .ov_hi_i     (ov_hi),
      .ov_lo_i     (ov_lo),
      .oe_i        (oe_i),
      .oe_ok_i     (oe_ok),
      .carry_upd_i (carry_upd),
      .ca_i        (ca_i),
      .ca32_i      (ca32_i),
      .so_i        (so_i),
      .ov_i        (ov_i),
      .ov32_i      (ov32_i),
      .ca_o        (ca_o),
      .ca32_o      (ca32_o),
      .ov_o        (ov_o),
      .ov32_o      (ov32_o),
      .so_o        (so_o),
      .cr0_o       (cr0_o)
   );

endmodule

// File: rtl/int_addsub_chk.sv
module int_addsub_chk
   import addsub_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input logic [2:0]      op_i,
   input logic            oe_i,
   input logic [XLEN-1:0] ra_i,
   input logic [XLEN-1:0] rb_i,
   input logic            ca_i,
   input logic            ca32_i,
   input logic            so_i,
   input logic            ov_i,
   input logic            ov32_i,
   input logic [XLEN-1:0] res_o,
   input logic            ca_o,
   input logic            ca32_o,
   input logic            ov_o,
   input logic            ov32_o,
   input logic            so_o,
   input logic [3:0]      cr0_o
);

   addsub_op_e op;
   logic       no_carry_op;
   logic       no_ov_op;

   assign op          = addsub_op_e'(op_i);
   assign no_carry_op = (op == OP_ADD) || (op == OP_SUBF) || (op == OP_ADDI)
                        || (op == OP_ADDIS) || (op == OP_RSV);
   assign no_ov_op    = (op == OP_ADDI) || (op == OP_ADDIS) || !oe_i;

   always_comb begin
      if (!$isunknown({op_i, oe_i, ra_i, rb_i, ca_i, ca32_i, so_i, ov_i, ov32_i})) begin
         if (op == OP_SUBF) begin
            a_r2_subf_inverse: assert ((res_o + ra_i) == rb_i)
               else $error("subtract-from result plus RA differs from RB");
         end
         if (no_carry_op) begin
            a_r1_carry_hold: assert (ca_o == ca_i && ca32_o == ca32_i)
               else $error("carry changed by an operation that keeps it");
         end
         if (op == OP_ADDZE && !ca_i) begin
            a_r7_addze_identity: assert (res_o == ra_i && !ca_o && !ca32_o)
               else $error("add-to-zero without carry altered the operand");
         end
         if (op == OP_ADDME && !ca_i && ra_i != '0) begin
            a_r6_addme_borrow: assert (ca_o)
               else $error("add-to-minus-one of nonzero operand lost its carry");
         end
         if (so_i) begin
            a_r8_so_sticky: assert (so_o)
               else $error("summary overflow cleared");
         end
         if (no_ov_op) begin
            a_r8_ov_hold: assert (ov_o == ov_i && ov32_o == ov32_i && so_o == so_i)
               else $error("overflow state changed without overflow enable");
         end
         a_r9_cr0_one_class: assert ($countones(cr0_o[3:1]) == 1)
            else $error("condition field does not hold exactly one class");
         a_r9_so_copy: assert (cr0_o[CR_SO] == so_o)
            else $error("condition field SO bit differs from updated SO");
         a_r9_sign: assert (cr0_o[CR_LT] == res_o[XLEN-1])
            else $error("LT bit disagrees with the result sign");
      end
   end

endmodule

bind int_addsub int_addsub_chk #(.XLEN(XLEN)) u_chk (
   .op_i   (op_i),
   .oe_i   (oe_i),
   .ra_i   (ra_i),
   .rb_i   (rb_i),
   .ca_i   (ca_i),
   .ca32_i (ca32_i),
   .so_i   (so_i),
   .ov_i   (ov_i),
   .ov32_i (ov32_i),
   .res_o  (res_o),
   .ca_o   (ca_o),
   .ca32_o (ca32_o),
   .ov_o   (ov_o),
   .ov32_o (ov32_o),
   .so_o   (so_o),
   .cr0_o  (cr0_o)
);

// File: tb/int_addsub_bench.sv
module int_addsub_bench;

   // small configuration swept exhaustively
   localparam int SW = 5;
   localparam int SH = 2;
   localparam int SI = 2;
   localparam int SS = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   // full-width instance
   logic [2:0]  op;
   logic        oe, rz, ca, ca32, so, ov, ov32;
   logic [63:0] ra, rb;
   logic [15:0] imm;
   logic [63:0] res;
   logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
   logic [3:0]  cr0;

   int_addsub u_int_addsub (
      .op_i(op), .oe_i(oe), .ra_zero_i(rz), .ra_i(ra), .rb_i(rb), .imm_i(imm),
      .ca_i(ca), .ca32_i(ca32), .so_i(so), .ov_i(ov), .ov32_i(ov32),
      .res_o(res), .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o),
      .so_o(so_o), .cr0_o(cr0)
   );

   // small instance, flat-adder variant
   logic [2:0]    s_op;
   logic          s_oe, s_rz, s_ca, s_ca32, s_so, s_ov, s_ov32;
   logic [SW-1:0] s_ra, s_rb;
   logic [SI-1:0] s_imm;
   logic [SW-1:0] s_res;
   logic          s_ca_o, s_ca32_o, s_ov_o, s_ov32_o, s_so_o;
   logic [3:0]    s_cr0;

   int_addsub #(.XLEN(SW), .HALF(SH), .IMM_W(SI), .SHIFT(SS), .CARRY_SPLIT(1'b0))
   u_int_addsub_small (
      .op_i(s_op), .oe_i(s_oe), .ra_zero_i(s_rz), .ra_i(s_ra), .rb_i(s_rb), .imm_i(s_imm),
      .ca_i(s_ca), .ca32_i(s_ca32), .so_i(s_so), .ov_i(s_ov), .ov32_i(s_ov32),
      .res_o(s_res), .ca_o(s_ca_o), .ca32_o(s_ca32_o), .ov_o(s_ov_o), .ov32_o(s_ov32_o),
      .so_o(s_so_o), .cr0_o(s_cr0)
   );

   task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic signed [127:0] sxn(input logic [63:0] x, input int n);
      logic [127:0] u;
      u = {64'd0, x} & ((128'd1 << n) - 128'd1);
      if (u[n-1]) return $signed(u) - $signed(128'd1 << n);
      return $signed(u);
   endfunction

   function automatic logic out_of_range(input logic signed [127:0] v, input int n);
      logic signed [127:0] hi, lo;
      hi = $signed(128'd1 << (n - 1)) - 128'sd1;
      lo = -$signed(128'd1 << (n - 1));
      return (v > hi) || (v < lo);
   endfunction

   // reference model built from the requirements
   task automatic model(input int w, h, iw, sh, input int opc,
                        input logic [63:0] xa, xb, xi,
                        input logic xrz, xca, xca32, xso, xov, xov32, xoe,
                        output logic [63:0] eres, output logic eca, eca32, eov, eov32, eso,
                        output logic [3:0] ecr);
      logic [127:0] m, hm, ie, shimm, base, ut;
      logic [63:0]  pa, pb;
      logic signed [127:0] st, sl, k;
      logic sub, cop, ook, o64, o32;
      m  = (128'd1 << w) - 1;
      hm = (128'd1 << h) - 1;
      ie = {64'd0, xi} & ((128'd1 << iw) - 1);
      if (ie[iw-1]) ie = ie | (m & ~((128'd1 << iw) - 1));
      shimm = (ie << sh) & m;
      base  = xrz ? 128'd0 : ({64'd0, xa} & m);
      sub = 1'b0; cop = 1'b0; ook = 1'b1; k = 0;
      pa = xa; pb = xb;
      case (opc)
         1: sub = 1'b1;
         2: begin pa = base[63:0]; pb = ie[63:0];    ook = 1'b0; end
         3: begin pa = base[63:0]; pb = shimm[63:0]; ook = 1'b0; end
         4: begin k = xca; cop = 1'b1; end
         5: begin pb = m[63:0]; k = xca; cop = 1'b1; end
         6: begin pb = 64'd0;   k = xca; cop = 1'b1; end
         default: ;
      endcase
      st = sxn(pb, w) + (sub ? -sxn(pa, w) : sxn(pa, w)) + k;
      sl = sxn(pb, h) + (sub ? -sxn(pa, h) : sxn(pa, h)) + k;
      eres = st[63:0] & m[63:0];
      o64 = out_of_range(st, w);
      o32 = out_of_range(sl, h);
      ut = ({64'd0, pa} & m) + ({64'd0, pb} & m) + k;
      eca   = cop ? ut[w] : xca;
      ut = ({64'd0, pa} & hm) + ({64'd0, pb} & hm) + k;
      eca32 = cop ? ut[h] : xca32;
      eov   = (ook && xoe) ? o64 : xov;
      eov32 = (ook && xoe) ? o32 : xov32;
      eso   = xso | (ook & xoe & o64);
      ecr[3] = eres[w-1];
      ecr[1] = (eres == 64'd0);
      ecr[2] = !ecr[3] && !ecr[1];
      ecr[0] = eso;
   endtask

   task automatic drive64(input logic [2:0] o, input logic e, z,
                          input logic [63:0] a, b, input logic [15:0] i,
                          input logic c, c32, s, v, v32);
      @(negedge clk);
      op = o; oe = e; rz = z; ra = a; rb = b; imm = i;
      ca = c; ca32 = c32; so = s; ov = v; ov32 = v32;
      #1;
   endtask

   function automatic string op_tag(input int o);
      case (o)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R10";
      endcase
   endfunction

   initial begin
      logic [63:0] eres;
      logic eca, eca32, eov, eov32, eso;
      logic [3:0] ecr;

      s_op = '0; s_oe = 0; s_rz = 0; s_ra = '0; s_rb = '0; s_imm = '0;
      s_ca = 0; s_ca32 = 0; s_so = 0; s_ov = 0; s_ov32 = 0;

      // idle state: all inputs zero gives zero result classed EQ
      drive64(3'd0, 0, 0, 64'd0, 64'd0, 16'd0, 0, 0, 0, 0, 0);
      check("R9 idle", {res, ca_o, ca32_o, ov_o, ov32_o, so_o, cr0},
            {64'd0, 5'b00000, 4'b0010});

      // R1 record add with negative result, carry left alone
      drive64(3'd0, 0, 0, 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 16'd0, 1, 0, 0, 0, 0);
      check("R1 add negative", {res, ca_o, ca32_o, cr0},
            {64'ha709a363416426bd, 2'b10, 4'b1000});
      drive64(3'd0, 0, 0, 64'h2e08ae202742baf8, 64'h86c43ece9efe5baa, 16'd0, 0, 1, 0, 0, 0);
      check("R1 add", {res, ca_o, ca32_o}, {64'hb4cceceec64116a2, 2'b01});

      // R2 operand order of subtract-from
      drive64(3'd1, 0, 0, 64'h3d7f3f7ca24bac7b, 64'hf6b2ac5e13ee15c2, 16'd0, 0, 0, 0, 0, 0);
      check("R2 subf a", res, 64'hb9336ce171a26947);
      drive64(3'd1, 0, 0, 64'h833652d96c7c0058, 64'h1c27ecff8a086c1a, 16'd0, 0, 0, 0, 0, 0);
      check("R2 subf b", res, 64'h98f19a261d8c6bc2);

      // R3 most negative immediate
      drive64(3'd2, 0, 0, 64'h10, 64'd0, 16'h8000, 0, 0, 0, 0, 0);
      check("R3 addi min imm", res, 64'hffffffffffff8010);
      drive64(3'd2, 0, 1, 64'h1234, 64'd0, 16'h7fff, 0, 0, 0, 0, 0);
      check("R3 addi zero base", res, 64'h7fff);

      // R4 literal zero base despite a nonzero register
      drive64(3'd3, 0, 1, 64'd5, 64'd0, 16'd1, 0, 0, 0, 0, 0);
      check("R4 addis zero base", {res, cr0}, {64'h10000, 4'b0100});

      // R5 extended add wrapping to zero
      drive64(3'd4, 0, 0, 64'hffffffffffffffff, 64'd0, 16'd0, 1, 0, 0, 0, 0);
      check("R5 adde wrap", {res, ca_o, ca32_o, cr0}, {64'd0, 2'b11, 4'b0010});

      // R6 add to minus one, carry-in clear
      drive64(3'd5, 0, 0, 64'h7ffffffff, 64'd0, 16'd0, 0, 0, 0, 0, 0);
      check("R6 addme a", {res, ca_o, ca32_o, cr0}, {64'h7fffffffe, 2'b11, 4'b0100});
      drive64(3'd5, 0, 0, 64'hffff80000, 64'd0, 16'd0, 0, 0, 0, 0, 0);
      check("R6 addme b", {res, ca_o, ca32_o}, {64'hffff7ffff, 2'b11});

      // R9 sticky SO reaches the condition field
      drive64(3'd5, 0, 0, 64'h7ffffffff, 64'd0, 16'd0, 1, 0, 1, 0, 0);
      check("R9 so copy", {res, so_o, cr0}, {64'h7ffffffff, 1'b1, 4'b0101});

      // R7 add to zero, carry-in clear
      drive64(3'd6, 0, 0, 64'h00ff00ff00ff0080, 64'd0, 16'd0, 0, 1, 0, 0, 0);
      check("R7 addze", {res, ca_o, ca32_o}, {64'h00ff00ff00ff0080, 2'b00});

      // R8 full-width overflow only, then the same sum without enable
      drive64(3'd0, 1, 0, 64'h7fffffffffffffff, 64'd1, 16'd0, 0, 0, 0, 0, 0);
      check("R8 ov64", {ov_o, ov32_o, so_o, cr0}, {3'b101, 4'b1001});
      drive64(3'd0, 0, 0, 64'h7fffffffffffffff, 64'd1, 16'd0, 0, 0, 0, 0, 1);
      check("R8 hold", {ov_o, ov32_o, so_o}, 3'b010);
      drive64(3'd0, 1, 0, 64'h7fffffff, 64'd1, 16'd0, 0, 0, 0, 1, 0);
      check("R8 ov32 only", {ov_o, ov32_o, so_o}, 3'b010);

      // R10 reserved code acts as add
      drive64(3'd7, 0, 0, 64'h2e08ae202742baf8, 64'h86c43ece9efe5baa, 16'd0, 1, 0, 0, 0, 0);
      check("R10 reserved", {res, ca_o}, {64'hb4cceceec64116a2, 1'b1});

      // exhaustive sweep of the small configuration
      for (int o = 0; o < 8; o++) begin
         for (int a = 0; a < (1 << SW); a++) begin
            for (int b = 0; b < (1 << SW); b++) begin
               for (int c = 0; c < 8; c++) begin
                  @(negedge clk);
                  s_op = 3'(o); s_ra = SW'(a); s_rb = SW'(b); s_imm = SI'(b);
                  s_ca = c[0]; s_oe = c[1]; s_rz = c[2];
                  s_ca32 = ~c[0]; s_so = c[0] ^ c[2]; s_ov = c[1] ^ c[0]; s_ov32 = ~s_ov;
                  #1;
                  model(SW, SH, SI, SS, o, 64'(a), 64'(b), 64'(b & ((1 << SI) - 1)),
                        s_rz, s_ca, s_ca32, s_so, s_ov, s_ov32, s_oe,
                        eres, eca, eca32, eov, eov32, eso, ecr);
                  check(op_tag(o), {s_res, s_ca_o, s_ca32_o}, {eres[SW-1:0], eca, eca32});
                  check("R8", {s_ov_o, s_ov32_o, s_so_o}, {eov, eov32, eso});
                  check("R9", s_cr0, ecr);
               end
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1..: got hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule